// File: doc/BRIEF.md
# ADC Conversion Clock Prescaler

This block derives the conversion clock for an analog-to-digital converter from the system bus clock. A 5-bit setting field, written through a simple write port, selects a prescale factor. A fixed divide-by-two stage follows the prescaler, so the total division is always even and the output has a 50% duty cycle. The output is available as a registered clock level. It is also available as a one-cycle enable pulse on each rising edge, so converter logic can stay in the bus clock domain.

After reset the block divides by four. A new setting never cuts a half period short, because the counter only adopts the new divisor when the output starts a new period. Settings in the reserved upper code space raise a flag, and the block then falls back to the slowest legal division.

Top module: `adc_clk_prescaler`

## Requirements
- R1: After reset the setting is 00001, `conv_clk` and `conv_en` are low and `rsvd_flag` is low; the first periods after reset last 4 bus cycles with 2 high.
- R2: For a setting whose bits [4:3] are 00, the `conv_clk` period is 2×(N+1) bus cycles, with N the value of bits [2:0] (00000 gives 2, 00111 gives 16).
- R3: `conv_clk` is high for exactly N+1 bus cycles in each period and low for the same count.
- R4: `conv_en` is high for exactly one bus cycle per period, in the first cycle in which `conv_clk` is high.
- R5: A write with bits [4:3] not equal to 00 sets `rsvd_flag` from the cycle after the write; the block then divides by 16 whatever bits [2:0] hold.
- R6: A write with bits [4:3] equal to 00 clears `rsvd_flag` from the cycle after the write.
- R7: A setting written in the middle of a period takes effect only at the next rising edge of `conv_clk`; the period in progress completes with the old divisor.
- R8: While `cfg_we` is low, `cfg_wdata` has no effect on the division or on `rsvd_flag`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Setting write strobe |
| cfg_wdata | input | 5 | Prescale setting; [2:0] factor, [4:3] must be zero |
| conv_clk | output | 1 | Divided clock level, 50% duty |
| conv_en | output | 1 | One-cycle pulse at each rise of `conv_clk` |
| rsvd_flag | output | 1 | Current setting is reserved |

## Verification
On every cycle the assertions check the following. `conv_en` appears only with a rise of `conv_clk` and never on two cycles in a row. No level of `conv_clk` lasts longer than the largest legal half period. Each low half matches the high half before it, which is the symmetry that the reload rule protects. The flag follows every write and holds when no write occurs. The actual period for each setting, the reset default, the fallback to divide-by-16 and the deferred adoption of a mid-period write only show up in the bench's sweeps, which measure periods and high times at the ports.

// File: rtl/adc_presc_pkg.sv
package adc_presc_pkg;
  localparam int DEF_CODE_W = 5;
  localparam int DEF_SEL_W  = 3;
  localparam int DEF_RESET_CODE = 1;

  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } phase_e;
endpackage

// File: rtl/presc_code_reg.sv
module presc_code_reg #(
  parameter int CODE_W = adc_presc_pkg::DEF_CODE_W,
  parameter int SEL_W  = adc_presc_pkg::DEF_SEL_W,
  parameter int RESET_CODE = adc_presc_pkg::DEF_RESET_CODE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [CODE_W-1:0] wdata,
  output logic [SEL_W-1:0]  pend_n,
  output logic              rsvd
);
  localparam logic [CODE_W-1:0] RST_V = CODE_W'(RESET_CODE);

  logic [CODE_W-1:0] code_q;
  logic              wr_rsvd;

  generate
    if (CODE_W > SEL_W) begin : g_upper
      assign wr_rsvd = |wdata[CODE_W-1:SEL_W];
    end else begin : g_no_upper
      assign wr_rsvd = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= RST_V;
      rsvd   <= 1'b0;
    end else if (we) begin
      code_q <= wdata;
      rsvd   <= wr_rsvd;
    end
  end

  // Reserved setting falls back to the slowest legal factor.
  assign pend_n = rsvd ? {SEL_W{1'b1}} : code_q[SEL_W-1:0];
endmodule

// File: rtl/presc_counter.sv
module presc_counter #(
  parameter int SEL_W  = adc_presc_pkg::DEF_SEL_W,
  parameter int RESET_CODE = adc_presc_pkg::DEF_RESET_CODE
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] pend_n,
  input  logic             reload,
  output logic             terminal
);
  localparam logic [SEL_W-1:0] RST_N = SEL_W'(RESET_CODE);
  localparam logic [SEL_W-1:0] ONE   = SEL_W'(1);

  logic [SEL_W-1:0] cnt_q;
  logic [SEL_W-1:0] act_n_q;

  assign terminal = (cnt_q == act_n_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      act_n_q <= RST_N;
    end else begin
      if (terminal) begin
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + ONE;
      end
      // Divisor adopted only as a new output period begins.
      if (reload) begin
        act_n_q <= pend_n;
      end
    end
  end
endmodule

// File: rtl/presc_half_toggle.sv
module presc_half_toggle (
  input  logic clk,
  input  logic rst,
  input  logic terminal,
  output logic rise_now,
  output logic clk_q,
  output logic en_q
);
  import adc_presc_pkg::*;

  phase_e ph_q;

  assign rise_now = terminal && (ph_q == PH_LOW);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q <= PH_LOW;
      en_q <= 1'b0;
    end else begin
      if (terminal) begin
        ph_q <= (ph_q == PH_LOW) ? PH_HIGH : PH_LOW;
      end
      en_q <= rise_now;
    end
  end

  assign clk_q = (ph_q == PH_HIGH);
endmodule

// File: rtl/adc_clk_prescaler.sv
module adc_clk_prescaler #(
  parameter int CODE_W = adc_presc_pkg::DEF_CODE_W,
  parameter int SEL_W  = adc_presc_pkg::DEF_SEL_W,
  parameter int RESET_CODE = adc_presc_pkg::DEF_RESET_CODE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CODE_W-1:0] cfg_wdata,
  output logic              conv_clk,
  output logic              conv_en,
  output logic              rsvd_flag
);
  logic [SEL_W-1:0] pend_n;
  logic             terminal;
  logic             rise_now;

  presc_code_reg #(
    .CODE_W(CODE_W), .SEL_W(SEL_W), .RESET_CODE(RESET_CODE)
  ) code_i (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata),
    .pend_n(pend_n), .rsvd(rsvd_flag)
  );

  presc_counter #(
    .SEL_W(SEL_W), .RESET_CODE(RESET_CODE)
  ) cnt_i (
    .clk(clk), .rst(rst), .pend_n(pend_n), .reload(rise_now),
    .terminal(terminal)
  );

  presc_half_toggle tog_i (
    .clk(clk), .rst(rst), .terminal(terminal), .rise_now(rise_now),
    .clk_q(conv_clk), .en_q(conv_en)
  );
endmodule

// File: rtl/adc_clk_prescaler_chk.sv
module adc_clk_prescaler_chk #(
  parameter int CODE_W = adc_presc_pkg::DEF_CODE_W,
  parameter int SEL_W  = adc_presc_pkg::DEF_SEL_W
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_we,
  input logic [CODE_W-1:0] cfg_wdata,
  input logic              conv_clk,
  input logic              conv_en,
  input logic              rsvd_flag
);
  localparam int RW = SEL_W + 2;
  localparam logic [RW-1:0] MAX_HALF = RW'(2 ** SEL_W);
  localparam logic [RW-1:0] ONE = RW'(1);

  logic          prev_q;
  logic [RW-1:0] run_q;
  logic [RW-1:0] hi_len_q;
  logic          hi_valid_q;
  logic          changed;

  assign changed = (conv_clk != prev_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q     <= 1'b0;
      run_q      <= '0;
      hi_len_q   <= '0;
      hi_valid_q <= 1'b0;
    end else begin
      prev_q <= conv_clk;
      if (changed) begin
        run_q <= ONE;
      end else if (run_q != '1) begin
        run_q <= run_q + ONE;
      end
      if (changed && !conv_clk) begin
        hi_len_q   <= run_q;
        hi_valid_q <= 1'b1;
      end
    end
  end

  AST_EN_AT_RISE: assert property (@(posedge clk) disable iff (rst)
    conv_en |-> (conv_clk && !prev_q)); // R4
  AST_RISE_HAS_EN: assert property (@(posedge clk) disable iff (rst)
    (conv_clk && !prev_q) |-> conv_en); // R4
  AST_EN_SINGLE: assert property (@(posedge clk) disable iff (rst)
    conv_en |=> !conv_en); // R4
  AST_HALF_BOUND: assert property (@(posedge clk) disable iff (rst)
    changed |-> (run_q <= MAX_HALF)); // R2
  AST_DUTY_SYM: assert property (@(posedge clk) disable iff (rst)
    (changed && conv_clk && hi_valid_q) |-> (run_q == hi_len_q)); // R3
  AST_FLAG_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (rsvd_flag == $past((cfg_wdata >> SEL_W) != '0))); // R5
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> $stable(rsvd_flag)); // R8
endmodule

bind adc_clk_prescaler adc_clk_prescaler_chk #(
  .CODE_W(CODE_W), .SEL_W(SEL_W)
) chk_i (.*);

// File: tb/adc_clk_prescaler_tb_top.sv
module adc_clk_prescaler_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 100000;

  logic       clk = 1'b0;
  logic       rst;
  logic       cfg_we;
  logic [4:0] cfg_wdata;
  logic       conv_clk;
  logic       conv_en;
  logic       rsvd_flag;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  adc_clk_prescaler dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .conv_clk(conv_clk), .conv_en(conv_en), .rsvd_flag(rsvd_flag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic write_cfg(input logic [4:0] v);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_en();
    do @(negedge clk); while (!conv_en);
  endtask

  // Sync to an enable pulse, then count one full period and its high cycles.
  task automatic measure(output int p, output int h);
    logic prev;
    prev = conv_clk;
    @(negedge clk);
    while (!conv_en) begin
      prev = conv_clk;
      @(negedge clk);
    end
    check(conv_clk && !prev, "R4 enable at first high cycle", int'(conv_clk), 1);
    p = 1;
    h = 1;
    forever begin
      @(negedge clk);
      if (conv_en) break;
      p++;
      if (conv_clk) h++;
    end
  endtask

  task automatic expect_div(input int n, input string req);
    int p, h;
    wait_en();
    measure(p, h);
    check(p == 2 * (n + 1), {req, " period"}, p, 2 * (n + 1));
    check(h == n + 1, {req, " high time (R3)"}, h, n + 1);
  endtask

  initial begin
    int p, h;
    rst = 1'b1;
    cfg_we = 1'b0;
    cfg_wdata = '0;
    repeat (3) @(negedge clk);
    check(conv_clk == 1'b0, "R1 reset clk low", int'(conv_clk), 0);
    check(conv_en == 1'b0, "R1 reset enable low", int'(conv_en), 0);
    check(rsvd_flag == 1'b0, "R1 reset flag low", int'(rsvd_flag), 0);
    rst = 1'b0;
    measure(p, h);
    check(p == 4, "R1 default period", p, 4);
    check(h == 2, "R1 default high time", h, 2);

    for (int n = 0; n < 8; n++) begin
      write_cfg(5'(n));
      check(rsvd_flag == 1'b0, "R6 legal flag", int'(rsvd_flag), 0);
      expect_div(n, "R2 legal sweep");
    end

    // R8: data without strobe is ignored
    write_cfg(5'b00010);
    cfg_wdata = 5'b11111;
    expect_div(2, "R8 no-strobe");
    check(rsvd_flag == 1'b0, "R8 flag untouched", int'(rsvd_flag), 0);
    cfg_wdata = '0;

    // R5: reserved settings
    write_cfg(5'b01000);
    check(rsvd_flag == 1'b1, "R5 flag 01000", int'(rsvd_flag), 1);
    expect_div(7, "R5 fallback 01000");
    write_cfg(5'b10001);
    check(rsvd_flag == 1'b1, "R5 flag 10001", int'(rsvd_flag), 1);
    expect_div(7, "R5 fallback 10001");
    write_cfg(5'b11010);
    check(rsvd_flag == 1'b1, "R5 flag 11010", int'(rsvd_flag), 1);
    expect_div(7, "R5 fallback 11010");

    // R6: a legal setting clears the flag
    write_cfg(5'b00011);
    check(rsvd_flag == 1'b0, "R6 flag cleared", int'(rsvd_flag), 0);
    expect_div(3, "R6 after clear");

    // R7: mid-period write defers to next rising edge
    write_cfg(5'b00111);
    wait_en();
    measure(p, h);
    @(negedge clk);
    while (!conv_en) @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = 5'b00000;
    p = 1;
    h = 1;
    forever begin
      @(negedge clk);
      cfg_we = 1'b0;
      if (conv_en) break;
      p++;
      if (conv_clk) h++;
    end
    check(p == 16, "R7 old period completes", p, 16);
    check(h == 8, "R7 old high time completes", h, 8);
    p = 1;
    h = 1;
    forever begin
      @(negedge clk);
      if (conv_en) break;
      p++;
      if (conv_clk) h++;
    end
    check(p == 2, "R7 new period applied", p, 2);
    check(h == 1, "R7 new high time applied", h, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule